// File: doc/BRIEF.md
# MSI Interrupt Request Controller

This block sits between user logic that raises message-signalled interrupts and the engine that forms and sends the messages. User logic drives a 32-bit vector of interrupt conditions together with request fields:
- the number of the function that raises the interrupt,
- three ordering/snoop attribute bits,
- a processing-hint flag, a hint type and a steering tag.

A 0-to-1 transition on any vector bit starts a request. On that edge the controller captures every field. It then checks the function's MSI enable and the function's multiple-message-enable (MME) allocation.

A request that passes both checks and is not masked goes out as one payload on a valid/ready handshake. A request whose vector is masked waits until the mask bit clears. Each accepted request ends in exactly one single-cycle `irq_sent` or `irq_fail` pulse. A fail pulse asks the requester to retry. Only one request is in flight at a time. An edge seen while busy is flagged and dropped.

Top module: `msi_req_ctrl`

## Requirements
- R1: A 0-to-1 transition on any `irq_vec` bit captures `irq_func`, the index of the rising bit, `irq_attr` (bit 0 no-snoop, bit 1 relaxed ordering, bit 2 ID-based ordering), `irq_tph_present`, `irq_tph_type` and `irq_tph_tag`. The downstream fields carry these captured values whatever the inputs do later, and they stay stable while `dn_valid` waits for `dn_ready`.
- R2: A request that passes all checks raises `dn_valid` two cycles after the cycle in which the edge was applied. When `dn_ready` is high at a clock edge while `dn_valid` is high, `dn_valid` drops and `irq_sent` is high for the next cycle.
- R3: With MME value m for the function, vector index v is allowed only if v < 2^min(m,5). A request outside that range gives an `irq_fail` pulse two cycles after the edge cycle, and `dn_valid` is never raised for it.
- R4: The function codes in use are 0 and 1 (physical functions) and 4 to 9 (virtual functions 0 to 5). The enable bit is `func_msi_en[code]`. A request for code 2, 3 or 10 to 15, or for a code whose enable bit is clear, gives an `irq_fail` pulse two cycles after the edge cycle. Enable bits 2 and 3 have no effect.
- R5: If mask bit `func_mask[code*32+v]` is set when the request is checked, no `dn_valid`, `irq_sent` or `irq_fail` appears while the bit stays set. The cycle after the bit clears, `dn_valid` rises.
- R6: `dn_abort` high at a clock edge while `dn_valid` is high ends the request with `irq_fail` in the next cycle. `dn_abort` takes priority over `dn_ready`.
- R7: A rising vector bit seen while a request is in flight gives a one-cycle `irq_proto_err` pulse in the next cycle. "In flight" runs from the capture edge through the sent or fail cycle. The bit starts no request.
- R8: Each accepted request ends in exactly one single-cycle pulse, either `irq_sent` or `irq_fail`. The two are never high together.
- R9: After reset, `dn_valid`, `irq_sent`, `irq_fail` and `irq_proto_err` are low.
- R10: A vector bit held high after its request completes does not start another request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_vec | input | 32 | Interrupt condition vector, one bit per vector |
| irq_func | input | 4 | Originating function code |
| irq_attr | input | 3 | Attribute bits for the message |
| irq_tph_present | input | 1 | Processing hint present |
| irq_tph_type | input | 2 | Processing hint type |
| irq_tph_tag | input | 9 | Steering tag with mode bit |
| func_msi_en | input | 10 | MSI enable per function code |
| func_mme | input | 30 | 3-bit MME field per function code |
| func_mask | input | 320 | 32 mask bits per function code |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_abort | input | 1 | Downstream aborts request |
| dn_func | output | 4 | Captured function code |
| dn_vec | output | 5 | Captured vector index |
| dn_attr | output | 3 | Captured attribute bits |
| dn_tph_present | output | 1 | Captured hint present flag |
| dn_tph_type | output | 2 | Captured hint type |
| dn_tph_tag | output | 9 | Captured steering tag |
| irq_sent | output | 1 | One-cycle sent pulse |
| irq_fail | output | 1 | One-cycle fail pulse |
| irq_proto_err | output | 1 | One-cycle protocol error pulse |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. It counts cycles from the cycle in which a vector bit rises, with that cycle numbered 0:
- The check decision happens in cycle 1, so `dn_valid` or a rejection `irq_fail` is sampled exactly in cycle 2, and cycle 1 is checked to be quiet.
- `irq_sent` or the abort `irq_fail` is sampled one cycle after the cycle in which `dn_ready` or `dn_abort` was high, and the cycle after that is checked to be quiet.
- `irq_proto_err` is sampled one cycle after the offending edge.
- For a masked request, the bench checks for silence over several held cycles, then expects `dn_valid` one cycle after the mask bit clears.

// File: rtl/msi_req_pkg.sv
package msi_req_pkg;
  localparam int NUM_VEC   = 32;
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int FUNC_W    = 4;
  localparam int NUM_PF    = 2;
  localparam int PF_SLOTS  = 4;
  localparam int NUM_VF    = 6;
  localparam int NUM_CODES = PF_SLOTS + NUM_VF;
  localparam int MME_W     = 3;
  localparam int ATTR_W    = 3;
  localparam int TPHT_W    = 2;
  localparam int TAG_W     = 9;

  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic [VEC_W-1:0]  vec;
    logic [ATTR_W-1:0] attr;
    logic              tph_p;
    logic [TPHT_W-1:0] tph_t;
    logic [TAG_W-1:0]  tag;
  } msi_req_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_HOLD, ST_SEND, ST_SENT, ST_FAIL
  } msi_st_e;

  function automatic logic code_used(input logic [FUNC_W-1:0] f);
    return (f < FUNC_W'(NUM_PF)) ||
           ((f >= FUNC_W'(PF_SLOTS)) && (f < FUNC_W'(NUM_CODES)));
  endfunction
endpackage

// File: rtl/msi_req_capture.sv
module msi_req_capture
  import msi_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_VEC-1:0] vec_in,
  input  logic [FUNC_W-1:0] func_in,
  input  logic [ATTR_W-1:0] attr_in,
  input  logic              tph_p_in,
  input  logic [TPHT_W-1:0] tph_t_in,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic              take,
  output logic              rise_any,
  output msi_req_t          req_q
);
  logic [NUM_VEC-1:0] prev_q;
  logic [NUM_VEC-1:0] rise;
  logic [VEC_W-1:0]   first_idx;
  msi_req_t           req_d;

  // edge detect and lowest rising index
  always_comb begin
    rise      = vec_in & ~prev_q;
    rise_any  = |rise;
    first_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (rise[i]) first_idx = VEC_W'(i);
    end
  end

  always_comb begin
    req_d = req_q;
    if (take) begin
      req_d.func  = func_in;
      req_d.vec   = first_idx;
      req_d.attr  = attr_in;
      req_d.tph_p = tph_p_in;
      req_d.tph_t = tph_t_in;
      req_d.tag   = tag_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= vec_in;
      req_q  <= req_d;
    end
  end
endmodule

// File: rtl/msi_req_policy.sv
module msi_req_policy
  import msi_req_pkg::*;
(
  input  msi_req_t                     req,
  input  logic [NUM_CODES-1:0]         fn_en,
  input  logic [NUM_CODES*MME_W-1:0]   mme_flat,
  input  logic [NUM_CODES*NUM_VEC-1:0] mask_flat,
  output logic                         allow,
  output logic                         masked
);
  logic [NUM_CODES-1:0] hit;
  logic                 en_bit;
  logic [MME_W-1:0]     mme_sel;
  logic [MME_W-1:0]     lim;
  logic [NUM_VEC-1:0]   mask_row;
  logic [VEC_W-1:0]     over;

  // one decoder line per function code
  for (genvar c = 0; c < NUM_CODES; c++) begin : g_dec
    assign hit[c] = (req.func == FUNC_W'(c));
  end

  always_comb begin
    en_bit   = 1'b0;
    mme_sel  = '0;
    mask_row = '0;
    for (int c = 0; c < NUM_CODES; c++) begin
      if (hit[c]) begin
        en_bit   = fn_en[c];
        mme_sel  = mme_flat[c*MME_W +: MME_W];
        mask_row = mask_flat[c*NUM_VEC +: NUM_VEC];
      end
    end
    lim    = (mme_sel > MME_W'(VEC_W)) ? MME_W'(VEC_W) : mme_sel;
    over   = req.vec >> lim;
    allow  = code_used(req.func) && en_bit && (over == '0);
    masked = mask_row[req.vec];
  end
endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
  import msi_req_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_any,
  input  logic allow,
  input  logic masked,
  input  logic dn_ready,
  input  logic dn_abort,
  output logic take,
  output logic dn_valid,
  output logic sent,
  output logic fail,
  output logic proto_err
);
  msi_st_e st_q, st_d;
  logic    err_q, err_d;

  always_comb begin
    st_d = st_q;
    take = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (rise_any) begin take = 1'b1; st_d = ST_CHECK; end
      ST_CHECK: begin
        if (!allow)      st_d = ST_FAIL;
        else if (masked) st_d = ST_HOLD;
        else             st_d = ST_SEND;
      end
      ST_HOLD:  if (!masked) st_d = ST_SEND;
      ST_SEND: begin
        if (dn_abort)      st_d = ST_FAIL;
        else if (dn_ready) st_d = ST_SENT;
      end
      ST_SENT:  st_d = ST_IDLE;
      ST_FAIL:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    err_d = (st_q != ST_IDLE) && rise_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign dn_valid  = (st_q == ST_SEND);
  assign sent      = (st_q == ST_SENT);
  assign fail      = (st_q == ST_FAIL);
  assign proto_err = err_q;

  // R8
  sent_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sent && fail));
  // R8
  sent_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sent |=> !sent);
  // R2
  ready_to_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && !dn_abort |=> sent && !dn_valid);
  // R6
  abort_to_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_abort |=> fail && !dn_valid);
  // R3
  reject_to_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK) && !allow |=> fail);
endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl
  import msi_req_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_VEC-1:0]           irq_vec,
  input  logic [FUNC_W-1:0]            irq_func,
  input  logic [ATTR_W-1:0]            irq_attr,
  input  logic                         irq_tph_present,
  input  logic [TPHT_W-1:0]            irq_tph_type,
  input  logic [TAG_W-1:0]             irq_tph_tag,
  input  logic [NUM_CODES-1:0]         func_msi_en,
  input  logic [NUM_CODES*MME_W-1:0]   func_mme,
  input  logic [NUM_CODES*NUM_VEC-1:0] func_mask,
  output logic                         dn_valid,
  input  logic                         dn_ready,
  input  logic                         dn_abort,
  output logic [FUNC_W-1:0]            dn_func,
  output logic [VEC_W-1:0]             dn_vec,
  output logic [ATTR_W-1:0]            dn_attr,
  output logic                         dn_tph_present,
  output logic [TPHT_W-1:0]            dn_tph_type,
  output logic [TAG_W-1:0]             dn_tph_tag,
  output logic                         irq_sent,
  output logic                         irq_fail,
  output logic                         irq_proto_err
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       take, rise_any, allow, masked;
  msi_req_t   req_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  msi_req_capture u_cap (
    .clk(clk), .rst_n(rst_n_int), .vec_in(irq_vec), .func_in(irq_func),
    .attr_in(irq_attr), .tph_p_in(irq_tph_present), .tph_t_in(irq_tph_type),
    .tag_in(irq_tph_tag), .take(take), .rise_any(rise_any), .req_q(req_q)
  );

  msi_req_policy u_pol (
    .req(req_q), .fn_en(func_msi_en), .mme_flat(func_mme),
    .mask_flat(func_mask), .allow(allow), .masked(masked)
  );

  msi_req_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_int), .rise_any(rise_any), .allow(allow),
    .masked(masked), .dn_ready(dn_ready), .dn_abort(dn_abort), .take(take),
    .dn_valid(dn_valid), .sent(irq_sent), .fail(irq_fail),
    .proto_err(irq_proto_err)
  );

  assign dn_func        = req_q.func;
  assign dn_vec         = req_q.vec;
  assign dn_attr        = req_q.attr;
  assign dn_tph_present = req_q.tph_p;
  assign dn_tph_type    = req_q.tph_t;
  assign dn_tph_tag     = req_q.tag;

  // R1
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    dn_valid && !dn_ready && !dn_abort |=> dn_valid && $stable(dn_func) &&
    $stable(dn_vec) && $stable(dn_attr) && $stable(dn_tph_tag) &&
    $stable(dn_tph_type) && $stable(dn_tph_present));
  // R8
  no_dual_end_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_fail |=> !irq_fail);
endmodule

// File: tb/msi_req_ctrl_test.sv
module msi_req_ctrl_test;
  localparam int EXP_OK = 0, EXP_FAIL = 1, EXP_HOLD = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [31:0]  irq_vec;
  logic [3:0]   irq_func;
  logic [2:0]   irq_attr;
  logic         irq_tph_present;
  logic [1:0]   irq_tph_type;
  logic [8:0]   irq_tph_tag;
  logic [9:0]   func_msi_en;
  logic [29:0]  func_mme;
  logic [319:0] func_mask;
  logic         dn_valid, dn_ready, dn_abort;
  logic [3:0]   dn_func;
  logic [4:0]   dn_vec;
  logic [2:0]   dn_attr;
  logic         dn_tph_present;
  logic [1:0]   dn_tph_type;
  logic [8:0]   dn_tph_tag;
  logic         irq_sent, irq_fail, irq_proto_err;

  int nvec = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  msi_req_ctrl uut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expect_of(input int f, input int v);
    int lim;
    if (!(f < 2 || (f >= 4 && f <= 9))) return EXP_FAIL;
    if (!func_msi_en[f]) return EXP_FAIL;
    lim = int'(func_mme[f*3 +: 3]);
    if (lim > 5) lim = 5;
    if (v >= (1 << lim)) return EXP_FAIL;
    if (func_mask[f*32 + v]) return EXP_HOLD;
    return EXP_OK;
  endfunction

  // caller is at a falling edge; this is cycle 0
  task automatic run_req(input int f, input int v, input int rdly, input bit abrt,
                         input bit inj, input bit hold);
    int          ex;
    logic [2:0]  a  = 3'($urandom);
    logic        tp = 1'($urandom);
    logic [1:0]  tt = 2'($urandom);
    logic [8:0]  tg = 9'($urandom);
    ex = expect_of(f, v);
    irq_vec = 32'd1 << v; irq_func = 4'(f); irq_attr = a;
    irq_tph_present = tp; irq_tph_type = tt; irq_tph_tag = tg;
    @(negedge clk);
    chk(!dn_valid && !irq_fail && !irq_sent, "R2 quiet in cycle 1", {dn_valid, irq_fail}, 0);
    irq_func = 4'($urandom); irq_attr = 3'($urandom); irq_tph_tag = 9'($urandom);
    irq_tph_type = 2'($urandom); irq_tph_present = 1'($urandom);
    if (inj) irq_vec = 32'd1 << ((v + 1) % 32);
    else if (!hold) irq_vec = '0;
    @(negedge clk);
    if (inj) begin
      chk(irq_proto_err == 1'b1, "R7 busy edge flagged", irq_proto_err, 1);
      irq_vec = '0;
    end else begin
      chk(irq_proto_err == 1'b0, "R7 no spurious error", irq_proto_err, 0);
    end
    if (ex == EXP_FAIL) begin
      chk(irq_fail && !dn_valid, "R3 R4 reject fail pulse", {irq_fail, dn_valid}, 2'b10);
      @(negedge clk);
      chk(!irq_fail && !irq_sent, "R8 fail one cycle", irq_fail, 0);
    end else begin
      if (ex == EXP_HOLD) begin
        for (int k = 0; k < 3; k++) begin
          chk(!dn_valid && !irq_fail && !irq_sent, "R5 masked held",
              {dn_valid, irq_fail, irq_sent}, 0);
          @(negedge clk);
        end
        func_mask[f*32 + v] = 1'b0;
        @(negedge clk);
      end
      chk(dn_valid == 1'b1, "R2 R5 valid due", dn_valid, 1);
      chk(dn_func == 4'(f) && dn_vec == 5'(v), "R1 func/vec captured",
          {dn_func, dn_vec}, {4'(f), 5'(v)});
      chk(dn_attr == a && dn_tph_present == tp && dn_tph_type == tt && dn_tph_tag == tg,
          "R1 attr/hint captured", {dn_attr, dn_tph_present, dn_tph_type, dn_tph_tag},
          {a, tp, tt, tg});
      for (int k = 0; k < rdly; k++) begin
        @(negedge clk);
        chk(dn_valid && dn_vec == 5'(v) && dn_tph_tag == tg, "R1 payload held",
            {dn_valid, dn_vec}, {1'b1, 5'(v)});
      end
      if (abrt) begin dn_abort = 1'b1; dn_ready = 1'($urandom); end
      else dn_ready = 1'b1;
      @(negedge clk);
      dn_ready = 1'b0; dn_abort = 1'b0;
      if (abrt) chk(irq_fail && !irq_sent && !dn_valid, "R6 abort fail", {irq_fail, irq_sent}, 2'b10);
      else      chk(irq_sent && !irq_fail && !dn_valid, "R2 sent pulse", {irq_sent, irq_fail}, 2'b10);
      @(negedge clk);
      chk(!irq_sent && !irq_fail, "R8 single pulse", {irq_sent, irq_fail}, 0);
    end
    if (hold) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!dn_valid && !irq_fail && !irq_sent, "R10 held bit no retrigger",
            {dn_valid, irq_fail}, 0);
      end
      irq_vec = '0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; irq_vec = '0; irq_func = '0; irq_attr = '0;
    irq_tph_present = 1'b0; irq_tph_type = '0; irq_tph_tag = '0;
    func_msi_en = '1; func_mme = {10{3'd5}}; func_mask = '0;
    dn_ready = 1'b0; dn_abort = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!dn_valid && !irq_sent && !irq_fail && !irq_proto_err, "R9 reset state",
        {dn_valid, irq_sent, irq_fail, irq_proto_err}, 0);

    // range boundaries
    func_mme[2:0] = 3'd2;
    run_req(0, 3, 0, 0, 0, 0);
    run_req(0, 4, 0, 0, 0, 0);
    func_mme[5:3] = 3'd7;
    run_req(1, 31, 1, 0, 0, 0);
    func_mme[14:12] = 3'd0;
    run_req(4, 0, 0, 0, 0, 0);
    run_req(4, 1, 0, 0, 0, 0);
    // function codes
    run_req(2, 0, 0, 0, 0, 0);
    run_req(3, 0, 0, 0, 0, 0);
    run_req(12, 0, 0, 0, 0, 0);
    func_msi_en[9] = 1'b0;
    run_req(9, 1, 0, 0, 0, 0);
    func_msi_en = '1;
    run_req(9, 1, 0, 0, 0, 0);
    // mask hold, abort, busy edge, held bit
    func_mask[5*32 + 6] = 1'b1;
    run_req(5, 6, 0, 0, 0, 0);
    run_req(6, 2, 2, 1, 0, 0);
    run_req(7, 9, 1, 0, 1, 0);
    run_req(8, 12, 0, 0, 0, 1);

    for (int n = 0; n < 400; n++) begin
      int f, v;
      for (int c = 0; c < 10; c++) func_mask[c*32 +: 32] = $urandom & $urandom;
      func_msi_en = 10'($urandom) | 10'($urandom);
      for (int c = 0; c < 10; c++) func_mme[c*3 +: 3] = 3'($urandom);
      if ($urandom_range(0, 3) != 0) begin
        f = $urandom_range(0, 7);
        if (f >= 2) f = f + 2;
      end else f = $urandom_range(0, 15);
      v = $urandom_range(0, 31);
      if (f < 10) func_mask[f*32 + v] = ($urandom_range(0, 4) == 0);
      run_req(f, v, $urandom_range(0, 3), ($urandom_range(0, 5) == 0),
              ($urandom_range(0, 7) == 0), 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule